// File: doc/BRIEF.md
# Multi-source timer interrupt combiner

This block collects the event flags of one timer channel into a single maskable interrupt request. Six hardware strobes (four compare-match events, a counter overflow and a counter underflow) each set a sticky flag in a status register. A separate enable register gates these flags. When the OR of the enabled flags rises, a latched request flag is set. The request drives the interrupt output unless the channel's mask bit is set. A two-bit priority field is passed through to an external arbiter.

Software finds the cause of an interrupt by reading the status register, which returns every flag as it stands. Flags clear only when software writes 0 to them; acknowledging the interrupt clears the request flag and leaves the status flags alone. Two identical instances serve two timer channels.

Top module: `tmr_irq_combiner`

## Requirements
- R1: After reset, the status and enable registers read 0, the request flag and the priority are 0, the mask flag is 1, and `irq_out` is 0.
- R2: A high bit on `evt_strobe` sets the matching status flag at that clock edge. Bit k, for k from 0 to 3, is compare event k. Bit 4 is overflow and bit 5 is underflow. A read at address 0 returns the six flags in bits 5:0 unmodified, with bits 7:6 reading 0.
- R3: A write to address 0 clears each status flag whose data bit is 0 and leaves unchanged each flag whose data bit is 1. If a strobe and a write-0 hit the same flag in the same cycle, the flag ends up set.
- R4: `irq_ack` never clears a status flag.
- R5: The enable register is at address 1. Bits 3:0 enable compare events 0 to 3, and bit 4 enables both overflow and underflow. Bits 7:5 read 0 and ignore writes. Address 3 reads 0 and ignores writes.
- R6: The request flag is set at the clock edge after the OR of the enabled status flags goes from 0 to 1. It is read at address 2, bit 0. A status flag whose enable is 0 never sets it.
- R7: `irq_ack`, or a write to address 2 with bit 0 equal to 0, clears the request flag. The flag then stays clear as long as the enabled OR stays high. A rising enabled OR in the same cycle as a clear leaves the flag set.
- R8: Address 2 holds the mask in bit 1 and the priority in bits 3:2, with bits 7:4 reading 0. `irq_out` equals request AND NOT mask. `irq_prio` equals the stored priority.
- R9: Either clearing sequence leaves all status flags at 0. One sequence writes 0 to the enable register and then 0 to every flag. The other writes 0 to every set flag while the enables stay set. Once the enables are 0, no new request arises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_adr | input | 2 | Register address (0 status, 1 enable, 2 control) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_adr`, combinational |
| evt_strobe | input | 6 | Hardware event strobes |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq_out | output | 1 | Masked interrupt request |
| irq_prio | output | 2 | Priority field for the external arbiter |

## Verification
The assertions assume that `reg_adr` and `reg_wdata` are known whenever `reg_wr` is high. They also assume that `evt_strobe` and `irq_ack` are never unknown outside reset. The stimulus drives every input to a defined value on each cycle, at the falling edge. It holds all inputs at 0 through three reset edges. The stimulus also deliberately overlaps strobes with write-0, and acknowledges with a rising enabled OR, because the precedence rules of R3 and R7 are what those properties watch.

// File: rtl/tic_pkg.sv
package tic_pkg;

    localparam int CMP_CNT_DEF = 4;
    localparam int REG_W_DEF   = 8;

    typedef enum logic [1:0] {
        ADR_STATUS = 2'd0,
        ADR_ENABLE = 2'd1,
        ADR_CTRL   = 2'd2,
        ADR_SPARE  = 2'd3
    } reg_sel_e;

    // Control word: request in bit 0, mask in bit 1, priority in bits 3:2
    typedef struct packed {
        logic [1:0] prio;
        logic       mask;
        logic       req;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic write_hits(input logic wr, input logic [1:0] adr,
                                        input reg_sel_e sel);
        return wr && (reg_sel_e'(adr) == sel);
    endfunction

endpackage

// File: rtl/tic_status_reg.sv
module tic_status_reg #(
    parameter int SRC_N = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_N-1:0] set_i,
    input  logic [SRC_N-1:0] clr_i,
    output logic [SRC_N-1:0] flag_o
);
    // One sticky flag per source; a hardware set beats a software clear
    generate
        for (genvar k = 0; k < SRC_N; k++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst) begin
                    flag_o[k] <= 1'b0;
                end else if (set_i[k]) begin
                    flag_o[k] <= 1'b1;
                end else if (clr_i[k]) begin
                    flag_o[k] <= 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/tic_enable_reg.sv
module tic_enable_reg #(
    parameter int EN_N = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_i,
    input  logic [EN_N-1:0] data_i,
    output logic [EN_N-1:0] en_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_o <= '0;
        end else if (wr_i) begin
            en_o <= data_i;
        end
    end
endmodule

// File: rtl/tic_source_gate.sv
module tic_source_gate #(
    parameter int CMP_N = 4
) (
    input  logic [CMP_N+1:0] flag_i,
    input  logic [CMP_N:0]   en_i,
    output logic             any_o
);
    localparam int SRC_N = CMP_N + 2;

    logic [SRC_N-1:0] hit;

    // Compare sources use their own enable; both counter sources share the top enable
    generate
        for (genvar k = 0; k < SRC_N; k++) begin : g_src
            if (k < CMP_N) begin : g_cmp
                assign hit[k] = flag_i[k] & en_i[k];
            end else begin : g_cnt
                assign hit[k] = flag_i[k] & en_i[CMP_N];
            end
        end
    endgenerate

    assign any_o = |hit;
endmodule

// File: rtl/tic_req_latch.sv
module tic_req_latch (
    input  logic clk,
    input  logic rst,
    input  logic cond_i,
    input  logic ack_i,
    input  logic sw_clr_i,
    output logic req_o
);
    logic cond_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_d <= 1'b0;
            req_o  <= 1'b0;
        end else begin
            cond_d <= cond_i;
            if (cond_i && !cond_d) begin
                req_o <= 1'b1;
            end else if (ack_i || sw_clr_i) begin
                req_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tmr_irq_combiner.sv
module tmr_irq_combiner
    import tic_pkg::*;
#(
    parameter int CMP_N = CMP_CNT_DEF,
    parameter int REG_W = REG_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [1:0]       reg_adr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic [CMP_N+1:0] evt_strobe,
    input  logic             irq_ack,
    output logic             irq_out,
    output logic [1:0]       irq_prio
);
    localparam int SRC_N = CMP_N + 2;
    localparam int EN_N  = CMP_N + 1;

    logic             wr_stat;
    logic             wr_en;
    logic             wr_ctrl;
    logic [SRC_N-1:0] stat_bits;
    logic [SRC_N-1:0] stat_clr;
    logic [EN_N-1:0]  en_bits;
    logic             any_hit;
    logic             req_flag;
    logic             mask_flag;
    logic [1:0]       prio_q;
    ctrl_t            ctrl_wr;
    ctrl_t            ctrl_view;
    logic             wdata_unused;

    assign wr_stat = write_hits(reg_wr, reg_adr, ADR_STATUS);
    assign wr_en   = write_hits(reg_wr, reg_adr, ADR_ENABLE);
    assign wr_ctrl = write_hits(reg_wr, reg_adr, ADR_CTRL);

    assign ctrl_wr      = ctrl_t'(reg_wdata[CTRL_W-1:0]);
    assign stat_clr     = wr_stat ? ~reg_wdata[SRC_N-1:0] : '0;
    assign wdata_unused = ^reg_wdata;

    tic_status_reg #(.SRC_N(SRC_N)) u_status (
        .clk    (clk),
        .rst    (rst),
        .set_i  (evt_strobe),
        .clr_i  (stat_clr),
        .flag_o (stat_bits)
    );

    tic_enable_reg #(.EN_N(EN_N)) u_enable (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (wr_en),
        .data_i (reg_wdata[EN_N-1:0]),
        .en_o   (en_bits)
    );

    tic_source_gate #(.CMP_N(CMP_N)) u_gate (
        .flag_i (stat_bits),
        .en_i   (en_bits),
        .any_o  (any_hit)
    );

    tic_req_latch u_req (
        .clk      (clk),
        .rst      (rst),
        .cond_i   (any_hit),
        .ack_i    (irq_ack),
        .sw_clr_i (wr_ctrl && !ctrl_wr.req),
        .req_o    (req_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_flag <= 1'b1;
            prio_q    <= 2'b00;
        end else if (wr_ctrl) begin
            mask_flag <= ctrl_wr.mask;
            prio_q    <= ctrl_wr.prio;
        end
    end

    always_comb begin
        ctrl_view.req  = req_flag;
        ctrl_view.mask = mask_flag;
        ctrl_view.prio = prio_q;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_sel_e'(reg_adr))
            ADR_STATUS: reg_rdata[SRC_N-1:0]  = stat_bits;
            ADR_ENABLE: reg_rdata[EN_N-1:0]   = en_bits;
            ADR_CTRL:   reg_rdata[CTRL_W-1:0] = ctrl_view;
            default:    reg_rdata = '0;
        endcase
    end

    assign irq_out  = req_flag & ~mask_flag;
    assign irq_prio = prio_q;

endmodule

// File: rtl/tic_checker.sv
module tic_checker #(
    parameter int CMP_N = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic [1:0]       reg_adr,
    input logic [CMP_N+1:0] wdata_lo,
    input logic [CMP_N+1:0] evt,
    input logic             ack,
    input logic [CMP_N+1:0] status_q,
    input logic [CMP_N:0]   en_q,
    input logic             any_hit,
    input logic             req_q,
    input logic             mask_q,
    input logic             irq_out
);
    logic             stat_wr;
    logic             en_wr;
    logic [CMP_N+1:0] clr_mask;

    assign stat_wr  = reg_wr && (reg_adr == 2'd0);
    assign en_wr    = reg_wr && (reg_adr == 2'd1);
    assign clr_mask = stat_wr ? ~wdata_lo : '0;

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (status_q == '0 && en_q == '0 && !req_q && mask_q && !irq_out))
        else $error("p_reset_state_r1");

    p_event_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((status_q & $past(evt)) == $past(evt)))
        else $error("p_event_sets_r2");

    p_only_write0_clears_r3: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (($past(status_q) & ~status_q & ~$past(clr_mask)) == '0))
        else $error("p_only_write0_clears_r3");

    p_ack_keeps_status_r4: assert property (@(posedge clk) disable iff (rst)
        (ack && !stat_wr) |=> (($past(status_q) & ~status_q) == '0))
        else $error("p_ack_keeps_status_r4");

    p_enable_write_r5: assert property (@(posedge clk) disable iff (rst)
        en_wr |=> (en_q == $past(wdata_lo[CMP_N:0])))
        else $error("p_enable_write_r5");

    p_rise_sets_req_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(any_hit) |=> req_q)
        else $error("p_rise_sets_req_r6");

    p_held_high_no_reset_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(any_hit) && any_hit && !req_q) |=> !req_q)
        else $error("p_held_high_no_reset_r7");

    p_mask_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        mask_q |-> !irq_out)
        else $error("p_mask_blocks_r8");

endmodule

bind tmr_irq_combiner tic_checker #(.CMP_N(CMP_N)) u_tic_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_adr  (reg_adr),
    .wdata_lo (reg_wdata[CMP_N+1:0]),
    .evt      (evt_strobe),
    .ack      (irq_ack),
    .status_q (stat_bits),
    .en_q     (en_bits),
    .any_hit  (any_hit),
    .req_q    (req_flag),
    .mask_q   (mask_flag),
    .irq_out  (irq_out)
);

// File: tb/test_tmr_irq_combiner.sv
`timescale 1ns/1ps
module test_tmr_irq_combiner;

    logic       clk = 1'b0;
    logic       rst;
    logic       reg_wr;
    logic [1:0] reg_adr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [5:0] evt_strobe;
    logic       irq_ack;
    logic       irq_out;
    logic [1:0] irq_prio;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 0;
    string cur_tag = "R1";

    // behavioural reference state
    logic [5:0] m_stat;
    logic [4:0] m_en;
    logic       m_req, m_mask, m_prev;
    logic [1:0] m_prio;

    always #4 clk = ~clk;

    tmr_irq_combiner i_tmr_irq_combiner (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_adr    (reg_adr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .evt_strobe (evt_strobe),
        .irq_ack    (irq_ack),
        .irq_out    (irq_out),
        .irq_prio   (irq_prio)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [1:0] a);
        case (a)
            2'd0:    return {2'b00, m_stat};
            2'd1:    return {3'b000, m_en};
            2'd2:    return {4'h0, m_prio, m_mask, m_req};
            default: return 8'h00;
        endcase
    endfunction

    task automatic cyc(input logic [5:0] e, input logic a, input logic w,
                       input logic [1:0] ad, input logic [7:0] d);
        logic       comb;
        logic [5:0] n_stat;
        logic [4:0] n_en;
        logic       n_req, n_mask;
        logic [1:0] n_prio;
        evt_strobe = e; irq_ack = a; reg_wr = w; reg_adr = ad; reg_wdata = d;
        comb   = |(m_stat & {m_en[4], m_en[4], m_en[3:0]});
        n_stat = e | (m_stat & ~((w && ad == 2'd0) ? ~d[5:0] : 6'h00));
        n_en   = (w && ad == 2'd1) ? d[4:0] : m_en;
        n_mask = (w && ad == 2'd2) ? d[1]   : m_mask;
        n_prio = (w && ad == 2'd2) ? d[3:2] : m_prio;
        if (comb && !m_prev)                        n_req = 1'b1;
        else if (a || (w && ad == 2'd2 && !d[0]))   n_req = 1'b0;
        else                                        n_req = m_req;
        @(posedge clk);
        m_stat = n_stat; m_en = n_en; m_mask = n_mask; m_prio = n_prio;
        m_req = n_req; m_prev = comb;
        @(negedge clk);
        check({cur_tag, " R8 irq_out"}, {7'd0, irq_out}, {7'd0, m_req & ~m_mask});
        check({cur_tag, " R8 irq_prio"}, {6'd0, irq_prio}, {6'd0, m_prio});
        check({cur_tag, " readback"}, reg_rdata, model_read(ad));
    endtask

    task automatic idle(input logic [1:0] ad);
        cyc(6'h00, 1'b0, 1'b0, ad, 8'h00);
    endtask

    task automatic wr(input logic [1:0] ad, input logic [7:0] d);
        cyc(6'h00, 1'b0, 1'b1, ad, d);
    endtask

    initial begin
        rst = 1'b1; reg_wr = 0; reg_adr = 0; reg_wdata = 0; evt_strobe = 0; irq_ack = 0;
        m_stat = 0; m_en = 0; m_req = 0; m_mask = 1; m_prev = 0; m_prio = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        cur_tag = "R1";
        idle(2'd2); check("R1 ctrl after reset", reg_rdata, 8'h02);
        check("R1 irq after reset", {7'd0, irq_out}, 8'h00);
        idle(2'd0); check("R1 status after reset", reg_rdata, 8'h00);
        idle(2'd1); check("R1 enable after reset", reg_rdata, 8'h00);

        cur_tag = "R2";
        cyc(6'h01, 0, 0, 2'd0, 8'h00); check("R2 compare0 flag", reg_rdata, 8'h01);
        idle(2'd2); check("R6 no request when disabled", reg_rdata, 8'h02);
        cyc(6'h3F, 0, 0, 2'd0, 8'h00); check("R2 all flags", reg_rdata, 8'h3F);

        cur_tag = "R3";
        wr(2'd0, 8'hFF); check("R3 write 1 no effect", reg_rdata, 8'h3F);

        cur_tag = "R4";
        cyc(6'h00, 1, 0, 2'd0, 8'h00); check("R4 ack keeps flags", reg_rdata, 8'h3F);

        cur_tag = "R5";
        wr(2'd1, 8'hFF); check("R5 spare enable bits", reg_rdata, 8'h1F);
        cur_tag = "R6";
        idle(2'd2); check("R6 request masked", reg_rdata, 8'h03);
        check("R8 masked irq", {7'd0, irq_out}, 8'h00);

        cur_tag = "R8";
        wr(2'd2, 8'h0D); check("R8 ctrl", reg_rdata, 8'h0D);
        check("R8 irq unmasked", {7'd0, irq_out}, 8'h01);
        check("R8 prio", {6'd0, irq_prio}, 8'h03);

        cur_tag = "R7";
        cyc(6'h00, 1, 0, 2'd2, 8'h00); check("R7 ack clears req", reg_rdata, 8'h0C);
        idle(2'd2); idle(2'd2); check("R7 held high stays clear", reg_rdata, 8'h0C);

        cur_tag = "R9";
        wr(2'd0, 8'h00); check("R9 clear with enables set", reg_rdata, 8'h00);

        cur_tag = "R5";
        wr(2'd1, 8'h10);
        cyc(6'h10, 0, 0, 2'd2, 8'h00);
        idle(2'd2); check("R5 overflow gated by bit4", reg_rdata, 8'h0D);
        cyc(6'h00, 1, 0, 2'd2, 8'h00);
        wr(2'd0, 8'h00);
        cyc(6'h20, 0, 0, 2'd2, 8'h00);
        idle(2'd2); check("R5 underflow gated by bit4", reg_rdata, 8'h0D);
        cyc(6'h00, 1, 0, 2'd2, 8'h00);
        wr(2'd0, 8'h00);
        cyc(6'h04, 0, 0, 2'd2, 8'h00);
        idle(2'd2); idle(2'd2); check("R5 compare2 not gated by bit4", reg_rdata, 8'h0C);

        cur_tag = "R3";
        cyc(6'h02, 0, 1, 2'd0, 8'h00); check("R3 set beats write0", reg_rdata, 8'h02);

        cur_tag = "R6";
        wr(2'd1, 8'h02);
        idle(2'd2); check("R6 enabled rise sets req", reg_rdata, 8'h0D);
        cur_tag = "R7";
        wr(2'd2, 8'h0C); check("R7 software clear", reg_rdata, 8'h0C);
        wr(2'd0, 8'h00);
        cyc(6'h02, 0, 0, 2'd0, 8'h00);
        cyc(6'h00, 1, 0, 2'd2, 8'h00); check("R7 rise beats ack", reg_rdata, 8'h0D);

        cur_tag = "R9";
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h00); check("R9 clear after disabling", reg_rdata, 8'h00);
        cyc(6'h00, 1, 0, 2'd2, 8'h00);
        cyc(6'h3F, 0, 0, 2'd0, 8'h00);
        idle(2'd2); idle(2'd2); check("R9 no request with enables off", reg_rdata, 8'h0C);

        cur_tag = "R5";
        wr(2'd3, 8'hFF); check("R5 spare address reads 0", reg_rdata, 8'h00);
        idle(2'd1); check("R5 spare write ignored", reg_rdata, 8'h00);

        cur_tag = "R8";
        wr(2'd2, 8'h06); check("R8 mask and prio", reg_rdata, 8'h06);
        check("R8 prio out", {6'd0, irq_prio}, 8'h01);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule